// File: doc/BRIEF.md
# Three-Digit Sequential Code Lock

The block is a synchronous door lock built from a small datapath and a control state machine. The datapath keeps three stored code digits. A one-hot multiplexer picks the digit for the current step, and a comparator checks that digit against the entry bus. The user presents three digits one after another on `entry_val`, and each digit is qualified by a one-cycle `entry_stb`. When every digit equals the stored digit in the same position, in order, the lock opens. Any wrong digit sends it to a failure state.

The controller has five states: STEP1, STEP2, STEP3, OPEN and FAIL. Their one-hot codes are STEP1=0001, STEP2=0010, STEP3=0100 and OPEN=1000, and FAIL has the all-zero code 0000. The low three state bits drive the digit-select multiplexer directly, and the top bit is the door output, so the outputs need no decode logic. The transitions are:

- STEP1→STEP2, STEP2→STEP3 and STEP3→OPEN, each on a strobed match.
- STEPk→FAIL on a strobed mismatch.
- Every state holds when there is no strobe.
- OPEN and FAIL hold on any input.
- Reset returns the lock to STEP1 from any state.

Each stored digit is written from `entry_val` through its own bit of `code_wr`. After reset the digits are 3, 4, 2.

Top module: `seq_code_lock`

## Requirements
- R1: Reset is synchronous and active high. It puts the lock in STEP1 (`step_sel`=001, `door_open`=0) and restores the default digits 3, 4, 2. It takes priority over `entry_stb` and `code_wr`.
- R2: In any state, a cycle with `entry_stb` low leaves the state unchanged, whatever `entry_val` holds.
- R3: A strobed digit that equals the selected stored digit advances the lock: STEP1→STEP2→STEP3→OPEN. `step_sel` shows 001, 010 and 100 in STEP1, STEP2 and STEP3, and 000 in OPEN.
- R4: A strobed digit that differs from the selected stored digit, in any of STEP1, STEP2 or STEP3, moves the lock to FAIL. In FAIL, `step_sel`=000 and `door_open`=0.
- R5: OPEN drives `door_open`=1 and holds against any later strobe or value until reset.
- R6: FAIL holds against any later strobe until reset, even when the correct sequence is entered.
- R7: With no write since reset, the sequence 3, 4, 2 opens the lock.
- R8: `code_wr[k]` writes `entry_val` into stored digit k+1 at the clock edge. Bit 0 writes the first digit, bit 1 the second and bit 2 the third. Several bits may be set together.
- R9: A write in the same cycle as a strobed entry does not affect that entry's comparison. The written value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| entry_val | input | 4 | Entered digit, also the write data for stored digits |
| entry_stb | input | 1 | Qualifies `entry_val` as an entry this cycle |
| code_wr | input | 3 | Per-digit write enables (bit k writes digit k+1) |
| door_open | output | 1 | High in OPEN |
| step_sel | output | 3 | One-hot digit select (the low state bits) |

## Verification
The hardest case to reach is the one where a write and a strobed entry land in the same cycle. A design that feeds the new write data straight into the comparator would still pass every ordinary sequence. The stimulus first writes the first digit as 8. It then strobes 3 while writing 3 into that digit, and the lock must fail against the old value 8. A second case strobes the correct first digit while rewriting the second digit. The second entry must then match the newly written value. The bench also forces a mismatch at each of the three steps, and it holds reset while strobes and writes are active.

// File: rtl/lock_pkg.sv
package lock_pkg;

    localparam int NUM_DIGITS = 3;

    typedef enum logic [3:0] {
        ST_FAIL  = 4'b0000,
        ST_STEP1 = 4'b0001,
        ST_STEP2 = 4'b0010,
        ST_STEP3 = 4'b0100,
        ST_OPEN  = 4'b1000
    } lock_state_e;

endpackage

// File: rtl/lock_code_bank.sv
module lock_code_bank
    import lock_pkg::*;
#(
    parameter int                         DW           = 4,
    parameter logic [NUM_DIGITS*DW-1:0]   DEFAULT_CODE = {4'd2, 4'd4, 4'd3}
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [DW-1:0]                     wr_data,
    input  logic [NUM_DIGITS-1:0]             wr_en,
    output logic [NUM_DIGITS-1:0][DW-1:0]     digits
);

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        always_ff @(posedge clk) begin
            if (rst) begin
                digits[k] <= DEFAULT_CODE[k*DW +: DW];
            end else if (wr_en[k]) begin
                digits[k] <= wr_data;
            end
        end

        // R8: a write enable stores the bus value at the next edge
        p_digit_write_r8: assert property (@(posedge clk) disable iff (rst)
            wr_en[k] |=> digits[k] == $past(wr_data));
    end

endmodule

// File: rtl/lock_digit_cmp.sv
module lock_digit_cmp
    import lock_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic [NUM_DIGITS-1:0][DW-1:0] digits,
    input  logic [NUM_DIGITS-1:0]         sel,
    input  logic [DW-1:0]                 entry_val,
    output logic                          match
);

    logic [DW-1:0] picked;

    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            picked = picked | (digits[k] & {DW{sel[k]}});
        end
        match = (|sel) && (picked == entry_val);
    end

    always_comb begin
        assert ($onehot0(sel)) else $error("p_sel_onehot_r3: select not one-hot");
    end

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
    import lock_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  entry_stb,
    input  logic                  match,
    output logic [NUM_DIGITS-1:0] sel,
    output logic                  door_open
);

    lock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STEP1: if (entry_stb) state_d = match ? ST_STEP2 : ST_FAIL;
            ST_STEP2: if (entry_stb) state_d = match ? ST_STEP3 : ST_FAIL;
            ST_STEP3: if (entry_stb) state_d = match ? ST_OPEN  : ST_FAIL;
            ST_OPEN:  state_d = ST_OPEN;
            ST_FAIL:  state_d = ST_FAIL;
            default:  state_d = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_STEP1;
        else     state_q <= state_d;
    end

    always_comb begin
        sel       = state_q[NUM_DIGITS-1:0];
        door_open = state_q[3];
    end

    // R2: no strobe, no movement
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !entry_stb |=> $stable(state_q));
    // R4: strobed mismatch in a step state lands in FAIL
    p_mismatch_fail_r4: assert property (@(posedge clk) disable iff (rst)
        (entry_stb && !match && (|state_q[2:0])) |=> state_q == ST_FAIL);
    // R5: OPEN is terminal until reset
    p_open_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_OPEN |=> state_q == ST_OPEN);
    // R6: FAIL is terminal until reset
    p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FAIL |=> state_q == ST_FAIL);

endmodule

// File: rtl/seq_code_lock.sv
module seq_code_lock
    import lock_pkg::*;
#(
    parameter int                       DW           = 4,
    parameter logic [NUM_DIGITS*DW-1:0] DEFAULT_CODE = {4'd2, 4'd4, 4'd3}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DW-1:0]         entry_val,
    input  logic                  entry_stb,
    input  logic [NUM_DIGITS-1:0] code_wr,
    output logic                  door_open,
    output logic [NUM_DIGITS-1:0] step_sel
);

    logic [NUM_DIGITS-1:0][DW-1:0] digits;
    logic                          match;

    lock_code_bank #(.DW(DW), .DEFAULT_CODE(DEFAULT_CODE)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_data (entry_val),
        .wr_en   (code_wr),
        .digits  (digits)
    );

    lock_digit_cmp #(.DW(DW)) u_cmp (
        .digits    (digits),
        .sel       (step_sel),
        .entry_val (entry_val),
        .match     (match)
    );

    lock_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .entry_stb (entry_stb),
        .match     (match),
        .sel       (step_sel),
        .door_open (door_open)
    );

endmodule

// File: tb/seq_code_lock_bench.sv
module seq_code_lock_bench;

    localparam logic [3:0] E_S1 = 4'b0001, E_S2 = 4'b0010, E_S3 = 4'b0100,
                           E_OP = 4'b1000, E_FL = 4'b0000;

    logic       clk = 0;
    logic       rst = 1;
    logic [3:0] entry_val = '0;
    logic       entry_stb = 0;
    logic [2:0] code_wr = '0;
    logic       door_open;
    logic [2:0] step_sel;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    seq_code_lock u_seq_code_lock (
        .clk(clk), .rst(rst), .entry_val(entry_val), .entry_stb(entry_stb),
        .code_wr(code_wr), .door_open(door_open), .step_sel(step_sel)
    );

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {door_open, step_sel};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {door,sel} actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive one cycle at the falling edge; result visible at the next falling edge
    task automatic drive(input logic [3:0] v, input logic s, input logic [2:0] w);
        @(negedge clk);
        entry_val = v; entry_stb = s; code_wr = w;
        @(negedge clk);
        entry_stb = 0; code_wr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; entry_stb = 1; code_wr = 3'b111; entry_val = 4'hF;
        @(negedge clk);
        @(negedge clk);
        rst = 0; entry_stb = 0; code_wr = '0;
    endtask

    task automatic t_reset_default();
        do_reset();
        chk("R1 reset state", E_S1);
        drive(4'd3, 1, 0); chk("R3 step1->step2", E_S2);
        drive(4'd4, 1, 0); chk("R3 step2->step3", E_S3);
        drive(4'd2, 1, 0); chk("R7 default code opens", E_OP);
    endtask

    task automatic t_idle_hold();
        do_reset();
        drive(4'd3, 1, 0);
        for (int i = 0; i < 4; i++) begin
            drive(4'd9, 0, 0); chk("R2 idle hold", E_S2);
        end
        drive(4'd4, 1, 0);
        drive(4'd2, 0, 0); chk("R2 idle hold step3", E_S3);
        drive(4'd2, 1, 0); chk("R3 opens after idles", E_OP);
    endtask

    task automatic t_mismatch();
        logic [3:0] good [3] = '{4'd3, 4'd4, 4'd2};
        for (int k = 0; k < 3; k++) begin
            do_reset();
            for (int j = 0; j < k; j++) drive(good[j], 1, 0);
            drive(good[k] ^ 4'h8, 1, 0);
            chk("R4 mismatch to fail", E_FL);
        end
    endtask

    task automatic t_fail_sticky();
        do_reset();
        drive(4'd7, 1, 0); chk("R4 fail at step1", E_FL);
        drive(4'd3, 1, 0); drive(4'd4, 1, 0); drive(4'd2, 1, 0);
        chk("R6 fail holds on correct code", E_FL);
        do_reset();
        chk("R1 reset leaves fail", E_S1);
    endtask

    task automatic t_open_sticky();
        do_reset();
        drive(4'd3, 1, 0); drive(4'd4, 1, 0); drive(4'd2, 1, 0);
        drive(4'd0, 1, 0); chk("R5 open holds on wrong", E_OP);
        drive(4'd3, 1, 0); chk("R5 open holds on strobe", E_OP);
        do_reset();
        chk("R1 reset leaves open", E_S1);
    endtask

    task automatic t_load();
        do_reset();
        drive(4'h9, 0, 3'b001);
        drive(4'hA, 0, 3'b010);
        drive(4'hB, 0, 3'b100);
        chk("R8 write leaves state", E_S1);
        drive(4'h9, 1, 0); drive(4'hA, 1, 0); drive(4'hB, 1, 0);
        chk("R8 new code opens", E_OP);
        do_reset();
        drive(4'h7, 0, 3'b111);
        drive(4'h3, 1, 0); chk("R8 old code rejected", E_FL);
        do_reset();
        drive(4'h7, 0, 3'b111);
        drive(4'h7, 1, 0); drive(4'h7, 1, 0); drive(4'h7, 1, 0);
        chk("R8 group write opens", E_OP);
        do_reset();
        drive(4'h3, 1, 0); drive(4'h4, 1, 0); drive(4'h2, 1, 0);
        chk("R1 reset restores default code", E_OP);
    endtask

    task automatic t_same_cycle();
        do_reset();
        drive(4'h8, 0, 3'b001);
        drive(4'h3, 1, 3'b001); chk("R9 compare uses old digit", E_FL);
        do_reset();
        drive(4'h3, 1, 3'b010); chk("R9 entry with write advances", E_S2);
        drive(4'h3, 1, 0); chk("R9 written digit used next", E_S3);
        drive(4'h2, 1, 0); chk("R9 finish opens", E_OP);
    endtask

    initial begin
        t_reset_default();
        t_idle_hold();
        t_mismatch();
        t_fail_sticky();
        t_open_sticky();
        t_load();
        t_same_cycle();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule